// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block watches the synchronised input levels of one bank of general-purpose pins and decides, pin by pin, whether each one is asking for interrupt service. Every pin has a small sense setting that arms any mix of four conditions: a rising transition, a falling transition, the pin being high, and the pin being low. Transitions are caught by comparing the level at each clock edge with the level seen at the edge before. An armed transition sets a sticky per-pin latch that holds until software clears it. Level conditions are not stored and follow the pin as it is.

A bank-wide enable word gates every pin. A disabled pin never reports, never latches, and loses any latched transition at the moment it is disabled. The gated requests of all pins are registered into a status word, and the bank interrupt line is the OR of that word. One instance serves one bank, and a chip with several banks uses one instance per bank, each with its own interrupt line and its own pin count.

Top module: `gpio_irq_bank`

## Requirements
- R1: During and right after synchronous reset, `status` and `irq` are 0, every pin's sense setting is 0 (nothing armed), all enable bits are 0 and every transition latch is empty.
- R2: A write with `ctrl_we` high stores `ctrl_wdata[3:0]` as the sense setting of pin `ctrl_idx`, and the new setting is used from the following clock edge. Bit 0 arms the falling transition, bit 1 the rising transition, bit 2 the low level and bit 3 the high level. A condition that is not armed never raises the pin's status.
- R3: An armed rising transition (level 1 now, 0 at the previous edge) or an armed falling transition (0 now, 1 before) sets the pin's latch. The latch keeps the status bit at 1 after the pin level returns.
- R4: With both transition bits armed, both a rising and a falling transition set the latch.
- R5: An armed level condition holds the status bit at 1 while the pin is at that level and lets it drop as soon as the level leaves, with no latching.
- R6: `ctrl_wdata[4]` set in a control write clears that pin's latch. A new transition on that pin at the same edge is discarded, and later transitions latch again. The same write also stores bits 3:0 as the sense setting.
- R7: Bit i of the enable word gates pin i. A write with `en_we` high loads `en_wdata` at that edge. A disabled pin shows status 0, does not latch, and loses its latched transition when it is disabled.
- R8: `irq` is 1 exactly when at least one `status` bit is 1, in the same cycle.
- R9: `status` and `irq` are registered. After each edge they show the pin levels sampled at that edge, the enable word as written at that edge, the latches as updated at that edge, and the sense settings in force before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | NPINS | Synchronised pin levels |
| ctrl_we | input | 1 | Per-pin control write strobe |
| ctrl_idx | input | IDX_W | Pin addressed by the control write |
| ctrl_wdata | input | 5 | [3:0] sense setting, [4] clear latch (self-clearing) |
| en_we | input | 1 | Enable word write strobe |
| en_wdata | input | NPINS | New enable word |
| status | output | NPINS | Registered per-pin service request |
| irq | output | 1 | Bank interrupt, OR of status |

## Verification
The assertions assume that `pin_lvl` is already synchronised to `clk`, so each bit holds one stable value per edge, and that `ctrl_idx` always addresses a pin that exists. The stimulus changes pins and strobes only on the falling clock edge and draws every control index from 0 to NPINS-1. On that basis the checks cover the enable gating, the enable write, the quiet state after reset and the OR relation between `status` and `irq`. The reference model separately follows the latch, clear and level behaviour edge by edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int SENSE_W = 4;
  localparam int CLR_BIT = 4;
  localparam int CTRL_W  = 5;

  // packed: first member is the MSB, so fall sits at bit 0
  typedef struct packed {
    logic hi;
    logic lo;
    logic rise;
    logic fall;
  } sense_t;
endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lvl,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              en_nxt,
  output logic              req
);
  sense_t sense_q;
  logic   prev_q;
  logic   latch_q;
  logic   latch_nxt;
  logic   rise_seen, fall_seen, edge_hit, lvl_hit, clr;

  always_comb begin
    rise_seen = lvl & ~prev_q;
    fall_seen = ~lvl & prev_q;
    edge_hit  = (rise_seen & sense_q.rise) | (fall_seen & sense_q.fall);
    lvl_hit   = (lvl & sense_q.hi) | (~lvl & sense_q.lo);
    clr       = wr_sel & wr_data[CLR_BIT];
    latch_nxt = (clr | ~en_nxt) ? 1'b0 : (latch_q | edge_hit);
    req       = latch_nxt | lvl_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      latch_q <= latch_nxt;
      if (wr_sel) sense_q <= sense_t'(wr_data[SENSE_W-1:0]);
    end
  end
endmodule

// File: rtl/gpio_irq_enable.sv
module gpio_irq_enable #(
  parameter int NPINS = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [NPINS-1:0] wd,
  output logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] en_nxt
);
  assign en_nxt = we ? wd : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end
endmodule

// File: rtl/gpio_irq_collect.sv
module gpio_irq_collect #(
  parameter int NPINS = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] req_vec,
  input  logic [NPINS-1:0] en_nxt,
  output logic [NPINS-1:0] status,
  output logic             irq
);
  logic [NPINS-1:0] status_d;

  assign status_d = req_vec & en_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |status_d;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 28,
  parameter int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              ctrl_we,
  input  logic [IDX_W-1:0]  ctrl_idx,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              en_we,
  input  logic [NPINS-1:0]  en_wdata,
  output logic [NPINS-1:0]  status,
  output logic              irq
);
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] en_nxt;
  logic [NPINS-1:0] req_vec;

  gpio_irq_enable #(.NPINS(NPINS)) u_en (
    .clk(clk), .rst(rst), .we(en_we), .wd(en_wdata),
    .en_q(en_q), .en_nxt(en_nxt)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic sel;
    assign sel = ctrl_we && (ctrl_idx == IDX_W'(i));
    gpio_irq_pin u_pin (
      .clk(clk), .rst(rst), .lvl(pin_lvl[i]),
      .wr_sel(sel), .wr_data(ctrl_wdata),
      .en_nxt(en_nxt[i]), .req(req_vec[i])
    );
  end

  gpio_irq_collect #(.NPINS(NPINS)) u_col (
    .clk(clk), .rst(rst), .req_vec(req_vec), .en_nxt(en_nxt),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             en_we,
  input logic [NPINS-1:0] en_wdata,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] status,
  input logic             irq
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (status == '0 && !irq)); // R1

  AST_GATED_BY_EN: assert property (@(posedge clk) disable iff (rst)
    (status & ~en_q) == '0); // R7

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
    en_we |=> en_q == $past(en_wdata)); // R7

  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (status & ~$past(en_wdata)) == '0); // R7

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    irq == (|status)); // R8
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
  .en_q(en_q), .status(status), .irq(irq)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int NP = 28;
  localparam int IW = 5;

  logic          clk = 0;
  logic          rst = 1;
  logic [NP-1:0] pin_lvl = '0;
  logic          ctrl_we = 0;
  logic [IW-1:0] ctrl_idx = '0;
  logic [4:0]    ctrl_wdata = '0;
  logic          en_we = 0;
  logic [NP-1:0] en_wdata = '0;
  logic [NP-1:0] status;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_irq_bank #(.NPINS(NP)) u_dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .ctrl_we(ctrl_we),
    .ctrl_idx(ctrl_idx), .ctrl_wdata(ctrl_wdata), .en_we(en_we),
    .en_wdata(en_wdata), .status(status), .irq(irq)
  );

  // behavioural reference model, advanced on each rising edge
  int            m_sense [NP];
  bit            m_latch [NP];
  bit            m_prev  [NP];
  bit            m_en    [NP];
  logic [NP-1:0] m_status = '0;
  bit            m_irq = 0;
  bit lv, ed, lc, ne, cl;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NP; i++) begin
        m_sense[i] = 0; m_latch[i] = 0; m_prev[i] = 0; m_en[i] = 0;
      end
      m_status = '0;
      m_irq = 0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        lv = pin_lvl[i];
        ed = (lv && !m_prev[i] && (m_sense[i] & 2) != 0) ||
             (!lv && m_prev[i] && (m_sense[i] & 1) != 0);
        lc = (lv && (m_sense[i] & 8) != 0) || (!lv && (m_sense[i] & 4) != 0);
        ne = en_we ? en_wdata[i] : m_en[i];
        cl = ctrl_we && (int'(ctrl_idx) == i) && ctrl_wdata[4];
        if (cl || !ne) m_latch[i] = 0;
        else if (ed)   m_latch[i] = 1;
        m_status[i] = ne && (m_latch[i] || lc);
        m_en[i] = ne;
        m_prev[i] = lv;
        if (ctrl_we && int'(ctrl_idx) == i) m_sense[i] = int'(ctrl_wdata[3:0]);
      end
      m_irq = (m_status != '0);
    end
  end

  // per-cycle comparison against the model (R9, R8)
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (status !== m_status || irq !== m_irq) begin
        n_fail++;
        $display("FAIL R9 cycle compare: status=%h irq=%0b expected status=%h irq=%0b",
                 status, irq, m_status, m_irq);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input int idx, input logic [4:0] d);
    ctrl_we = 1; ctrl_idx = IW'(idx); ctrl_wdata = d;
    tick();
    ctrl_we = 0; ctrl_wdata = '0;
  endtask

  task automatic wr_en(input logic [NP-1:0] w);
    en_we = 1; en_wdata = w;
    tick();
    en_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst = 0;
    tick();
    // R1 quiet after reset
    chk(status == '0, 1'b1, "R1 status zero after reset");
    chk(irq, 1'b0, "R1 irq low after reset");

    // R3 rising transition latches on pin 3
    wr_ctrl(3, 5'b0_0010);
    wr_en(28'h8);
    chk(status[3], 1'b0, "R3 no request before transition");
    pin_lvl[3] = 1; tick();
    chk(status[3], 1'b1, "R3 rising transition latched");
    chk(irq, 1'b1, "R8 irq follows status");
    pin_lvl[3] = 0; tick(); tick();
    chk(status[3], 1'b1, "R3 latch held after level returns");

    // R6 clear, then clear beating a simultaneous transition
    wr_ctrl(3, 5'b1_0010);
    chk(status[3], 1'b0, "R6 clear empties latch");
    chk(irq, 1'b0, "R8 irq low with no status");
    pin_lvl[3] = 1;
    wr_ctrl(3, 5'b1_0010);
    chk(status[3], 1'b0, "R6 clear wins over same-edge transition");
    tick();
    chk(status[3], 1'b0, "R6 discarded transition stays gone");

    // R3 falling only, R2 rising not armed
    wr_ctrl(3, 5'b1_0001);
    pin_lvl[3] = 0; tick();
    chk(status[3], 1'b1, "R3 falling transition latched");
    wr_ctrl(3, 5'b1_0001);
    pin_lvl[3] = 1; tick();
    chk(status[3], 1'b0, "R2 unarmed rising ignored");

    // R4 both transitions on pin 5
    wr_ctrl(5, 5'b0_0011);
    wr_en(28'h28);
    pin_lvl[5] = 1; tick();
    chk(status[5], 1'b1, "R4 rising with both armed");
    wr_ctrl(5, 5'b1_0011);
    chk(status[5], 1'b0, "R6 clear between transitions");
    pin_lvl[5] = 0; tick();
    chk(status[5], 1'b1, "R4 falling with both armed");

    // R5 level high on pin 7, level low on pin 8
    wr_ctrl(7, 5'b0_1000);
    wr_ctrl(8, 5'b0_0100);
    wr_en(28'h1A8);
    chk(status[8], 1'b1, "R5 low level reported while low");
    pin_lvl[7] = 1; tick();
    chk(status[7], 1'b1, "R5 high level reported");
    pin_lvl[7] = 0; pin_lvl[8] = 1; tick();
    chk(status[7], 1'b0, "R5 high level drops");
    chk(status[8], 1'b0, "R5 low level drops");

    // R7 disabling clears latch on pin 5 and blocks latching
    wr_en(28'h188);
    chk(status[5], 1'b0, "R7 disabled pin quiet");
    wr_en(28'h1A8);
    chk(status[5], 1'b0, "R7 latch lost on disable");
    wr_en(28'h188);
    pin_lvl[5] = 1; tick();
    wr_en(28'h1A8);
    chk(status[5], 1'b0, "R7 no latching while disabled");
    wr_en(28'h0);
    chk(irq, 1'b0, "R8 irq low with all disabled");

    // random phase, model compared every cycle (R9)
    for (int k = 0; k < 3000; k++) begin
      pin_lvl = pin_lvl ^ NP'($urandom & $urandom & $urandom);
      ctrl_we = ($urandom_range(0, 3) == 0);
      ctrl_idx = IW'($urandom_range(0, NP - 1));
      ctrl_wdata = 5'($urandom);
      en_we = ($urandom_range(0, 15) == 0);
      en_wdata = NP'($urandom);
      tick();
    end
    ctrl_we = 0; en_we = 0;
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule